// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the configuration store of an interrupt distributor for 128 interrupt lines. It sits behind a 4 KB register window. A single-cycle request port carries the address, the write flag, the access size and the write data. One cycle later the block returns read data and an error flag. A guest-select input picks one of several complete register copies on every access, so each guest sees a private view of control, group, enable, priority, target and trigger-configuration state.

Address bits [11:8] select a region. The enable state can be reached through a set window and a clear window, and both windows reach the same bits. Enable accesses may be byte, halfword or word wide. Every enable write that changes the stored word produces a one-cycle notification. The notification carries the guest, the word index and the new contents of the word, so that logic elsewhere can follow which lines are enabled. The regions that hold pending state, active state, secure access and software-generated interrupts are not implemented. An access to any of them is reported as an error.

Top module: `irq_dist_regbank`

## Requirements
- R1: Every request cycle produces a response (rsp_valid high) in the following cycle, and an idle cycle produces none. An errored access returns read data zero and leaves all state unchanged. A write response carries read data zero.
- R2: The control word at byte offset 0x000 is read/write and resets to zero. The control word, the group words, the priority words and the configuration words accept only word access (size code 2). Any other size is an error.
- R3: Offset 0x004 reads the line-count code NUM_LINES/32-1 (3 by default). Offset 0x008 reads 0x43B. A write to either offset is an error and changes nothing.
- R4: The group words sit at 0x080 to 0x08C and are read/write. A group index of 4 or more, and any other unlisted offset in region 0x0, is an error.
- R5: A write to the set window (0x100 to 0x10C) ORs the data into the enable word. A write to the clear window (0x180 to 0x18C) clears the bits that are set in the data. A read from either window returns the enable word. Any other offset in region 0x1 is an error.
- R6: The access size is coded as 0 for byte, 1 for halfword, 2 for word and 3 for illegal, and size 3 is always an error. For enable accesses, a halfword uses address bit 1 as the lane and a byte uses address bits [1:0] as the lane. Sub-word write data comes from the low bits of the write data, and a sub-word read returns the lane zero-extended.
- R7: An enable write whose lane data is all zero completes without error, changes nothing and raises no notification.
- R8: Each enable write with non-zero lane data pulses chg_valid for one cycle, in the same cycle as its response. The pulse carries the guest, the 2-bit word index and the resulting 32-bit enable word.
- R9: The priority words sit at 0x400 to 0x47C. There are 32 of them and they are read/write. An index of 32 or more in regions 0x4 to 0x7 is an error.
- R10: The target words sit at 0x800 to 0x87C and accept all three sizes, with lanes chosen as in R6. Words 0 to 7 always read zero, and writes to them are dropped without an error. An index of 32 or more is an error.
- R11: The configuration words sit at 0xC00 to 0xC1C. There are 8 of them and they are read/write. A higher index in region 0xC is an error.
- R12: Regions 0x2, 0x3, 0xD, 0xE and 0xF flag an error for every access, read as zero and ignore writes.
- R13: Each guest has its own copy of all writable state. A write made with one guest id is not visible to another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data (low bits for sub-word access) |
| guest_id | input | GUEST_W | Selects the register copy |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero-extended for sub-word reads |
| rsp_err | output | 1 | Access was illegal |
| chg_valid | output | 1 | Enable word changed by a write |
| chg_guest | output | GUEST_W | Guest whose enable word was written |
| chg_word | output | 2 | Enable word index |
| chg_bits | output | 32 | Resulting enable word |

## Verification
The enable-write response and the change notification come out of two separate register stages, and both must appear in the same cycle. A wrong stage in either path would split them. The bench writes through both windows with every byte lane and the upper halfword. In the one cycle after each write it samples the response and the notification together. It compares the guest, the word index and the full resulting word against a word built up by shifting and masking in the bench. All-zero writes through both windows check the other side: they must give a clean response with no notification in that same cycle.

// File: rtl/irqd_pkg.sv
// Shared types and lane helpers for the interrupt distributor register bank.
// Assumes a 32-bit data path; the lane helpers place sub-word data by size and
// the low address bits.
package irqd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_TYPE,
        TGT_IDENT,
        TGT_GROUP,
        TGT_EN_SET,
        TGT_EN_CLR,
        TGT_PRIO,
        TGT_ROUTE,
        TGT_CFG
    } acc_tgt_e;

    typedef struct packed {
        acc_tgt_e   tgt;
        logic [7:0] idx;
        logic       err;
    } acc_dec_t;

    function automatic logic [4:0] lane_shift(logic [1:0] size, logic [1:0] lane);
        case (size)
            SZ_BYTE: return {lane, 3'b000};
            SZ_HALF: return {lane[1], 4'b0000};
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(logic [1:0] size, logic [1:0] lane);
        case (size)
            SZ_BYTE: return 32'h0000_00FF << lane_shift(size, lane);
            SZ_HALF: return 32'h0000_FFFF << lane_shift(size, lane);
            SZ_WORD: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] lane_bits(logic [1:0] size, logic [1:0] lane, logic [31:0] wdata);
        case (size)
            SZ_BYTE: return {24'h0, wdata[7:0]} << lane_shift(size, lane);
            SZ_HALF: return {16'h0, wdata[15:0]} << lane_shift(size, lane);
            default: return wdata;
        endcase
    endfunction

    function automatic logic [31:0] lane_read(logic [1:0] size, logic [1:0] lane, logic [31:0] word);
        logic [31:0] tmp;
        tmp = word >> lane_shift(size, lane);
        case (size)
            SZ_BYTE: return {24'h0, tmp[7:0]};
            SZ_HALF: return {16'h0, tmp[15:0]};
            default: return word;
        endcase
    endfunction

endpackage

// File: rtl/irqd_decode.sv
// Address decoder: maps a 12-bit byte offset, the access size and the write
// flag to a target array, a word index and an error flag.
// Assumes NUM_LINES is a multiple of 32 and at most 1024.
module irqd_decode
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 128
) (
    input  logic [11:0] addr,
    input  logic [1:0]  size,
    input  logic        write,
    output acc_dec_t    dec
);
    localparam logic [8:0] GRP_LIM   = 9'(NUM_LINES / 32);
    localparam logic [8:0] EN_LIM    = 9'(NUM_LINES / 32);
    localparam logic [8:0] PRIO_LIM  = 9'(NUM_LINES / 4);
    localparam logic [8:0] ROUTE_LIM = 9'(NUM_LINES / 4);
    localparam logic [8:0] CFG_LIM   = 9'(NUM_LINES / 16);

    acc_tgt_e   tgt;
    logic [7:0] idx;
    logic       err;
    logic       word_sz;
    logic       any_sz;

    // Classify the access by region, then by offset within the region.
    always_comb begin
        tgt     = TGT_NONE;
        idx     = 8'd0;
        err     = 1'b1;
        word_sz = (size == SZ_WORD);
        any_sz  = (size != SZ_BAD);
        case (addr[11:8])
            4'h0: begin
                if (addr[7:2] == 6'd0) begin
                    tgt = TGT_CTRL;  err = !word_sz;
                end else if (addr[7:2] == 6'd1) begin
                    tgt = TGT_TYPE;  err = !word_sz || write;
                end else if (addr[7:2] == 6'd2) begin
                    tgt = TGT_IDENT; err = !word_sz || write;
                end else if (addr[7] && ({4'b0, addr[6:2]} < GRP_LIM)) begin
                    tgt = TGT_GROUP; idx = {3'b0, addr[6:2]}; err = !word_sz;
                end
            end
            4'h1: begin
                if ({4'b0, addr[6:2]} < EN_LIM) begin
                    tgt = addr[7] ? TGT_EN_CLR : TGT_EN_SET;
                    idx = {3'b0, addr[6:2]};
                    err = !any_sz;
                end
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                if ({1'b0, addr[9:2]} < PRIO_LIM) begin
                    tgt = TGT_PRIO; idx = addr[9:2]; err = !word_sz;
                end
            end
            4'h8, 4'h9, 4'hA, 4'hB: begin
                if ({1'b0, addr[9:2]} < ROUTE_LIM) begin
                    tgt = TGT_ROUTE; idx = addr[9:2]; err = !any_sz;
                end
            end
            4'hC: begin
                if ({3'b0, addr[7:2]} < CFG_LIM) begin
                    tgt = TGT_CFG; idx = {2'b0, addr[7:2]}; err = !word_sz;
                end
            end
            default: ;
        endcase
        dec = '{tgt: tgt, idx: idx, err: err};
    end

endmodule

// File: rtl/irqd_word_bank.sv
// Per-guest array of 32-bit words with masked (lane) writes.
// The first RO_WORDS entries ignore writes and stay at their reset value of zero.
// Assumes WORDS >= 2 and that idx is in range whenever wr_en is high.
module irqd_word_bank #(
    parameter int NUM_GUESTS = 2,
    parameter int WORDS      = 4,
    parameter int RO_WORDS   = 0,
    localparam int GW = $clog2(NUM_GUESTS),
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [GW-1:0] guest,
    input  logic [7:0]    idx,
    input  logic [31:0]   wmask,
    input  logic [31:0]   wbits,
    output logic [31:0]   rd_word
);
    logic [31:0]   mem_q [NUM_GUESTS][WORDS];
    logic [IW-1:0] wi;
    logic          ro_hit;
    logic [7:0]    unused_idx;

    assign wi         = idx[IW-1:0];
    assign unused_idx = idx;
    assign rd_word    = mem_q[guest][wi];

    if (RO_WORDS > 0) begin : g_ro
        assign ro_hit = ({1'b0, idx} < 9'(RO_WORDS));
    end else begin : g_rw
        assign ro_hit = 1'b0;
    end

    // Store lane-merged write data; read-only words never change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GUESTS; g++)
                for (int w = 0; w < WORDS; w++)
                    mem_q[g][w] <= '0;
        end else if (wr_en && !ro_hit) begin
            mem_q[guest][wi] <= (mem_q[guest][wi] & ~wmask) | (wbits & wmask);
        end
    end

endmodule

// File: rtl/irqd_enable_bank.sv
// Per-guest enable words reached through a set path and a clear path.
// Raises a one-cycle notification with the resulting word on every effective write.
// Assumes set_en and clr_en are never high together.
module irqd_enable_bank #(
    parameter int NUM_GUESTS = 2,
    parameter int WORDS      = 4,
    localparam int GW = $clog2(NUM_GUESTS),
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [GW-1:0] guest,
    input  logic [7:0]    idx,
    input  logic [31:0]   wmask,
    input  logic [31:0]   wbits,
    output logic [31:0]   rd_word,
    output logic          chg_valid,
    output logic [GW-1:0] chg_guest,
    output logic [IW-1:0] chg_word,
    output logic [31:0]   chg_bits
);
    logic [31:0]   en_q [NUM_GUESTS][WORDS];
    logic [IW-1:0] wi;
    logic [31:0]   cur, hit, nxt;
    logic          act;
    logic [7:0]    unused_idx;

    assign wi         = idx[IW-1:0];
    assign unused_idx = idx;
    assign cur        = en_q[guest][wi];
    assign hit        = wbits & wmask;
    assign act        = (set_en || clr_en) && (hit != 32'h0);
    assign nxt        = set_en ? (cur | hit) : (cur & ~hit);
    assign rd_word    = cur;

    // Update the addressed enable word on a write with non-zero lane data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GUESTS; g++)
                for (int w = 0; w < WORDS; w++)
                    en_q[g][w] <= '0;
        end else if (act) begin
            en_q[guest][wi] <= nxt;
        end
    end

    // Register the change notification alongside the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_valid <= 1'b0;
            chg_guest <= '0;
            chg_word  <= '0;
            chg_bits  <= '0;
        end else begin
            chg_valid <= act;
            if (act) begin
                chg_guest <= guest;
                chg_word  <= wi;
                chg_bits  <= nxt;
            end
        end
    end

endmodule

// File: rtl/irq_dist_regbank.sv
// Interrupt distributor configuration register bank with per-guest copies.
// Decodes each request, steers writes to the storage arrays and returns a
// registered response one cycle later. Assumes NUM_GUESTS is a power of two
// (at least 2) and NUM_LINES is a multiple of 32 in the range 64..1024.
module irq_dist_regbank
    import irqd_pkg::*;
#(
    parameter int          NUM_LINES   = 128,
    parameter int          NUM_GUESTS  = 2,
    parameter logic [31:0] IDENT_VALUE = 32'h0000_043B,
    localparam int GUEST_W = $clog2(NUM_GUESTS),
    localparam int EN_W    = $clog2(NUM_LINES / 32)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [11:0]        req_addr,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    input  logic [GUEST_W-1:0] guest_id,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_err,
    output logic               chg_valid,
    output logic [GUEST_W-1:0] chg_guest,
    output logic [EN_W-1:0]    chg_word,
    output logic [31:0]        chg_bits
);
    localparam int          GRP_WORDS   = NUM_LINES / 32;
    localparam int          PRIO_WORDS  = NUM_LINES / 4;
    localparam int          ROUTE_WORDS = NUM_LINES / 4;
    localparam int          CFG_WORDS   = NUM_LINES / 16;
    localparam int          ROUTE_RO    = 8;
    localparam logic [31:0] TYPE_VAL    = 32'(NUM_LINES / 32 - 1);

    acc_dec_t    dec;
    logic        acc_wr;
    logic [31:0] wmask, wbits;
    logic [31:0] grp_rd, en_rd, prio_rd, route_rd, cfg_rd;
    logic [31:0] rd_word, rdata_d;
    logic [31:0] ctrl_q [NUM_GUESTS];

    irqd_decode #(.NUM_LINES(NUM_LINES)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .write(req_write),
        .dec  (dec)
    );

    assign acc_wr = req_valid && req_write && !dec.err;
    assign wmask  = lane_mask(req_size, req_addr[1:0]);
    assign wbits  = lane_bits(req_size, req_addr[1:0], req_wdata);

    irqd_word_bank #(.NUM_GUESTS(NUM_GUESTS), .WORDS(GRP_WORDS)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_wr && dec.tgt == TGT_GROUP),
        .guest(guest_id), .idx(dec.idx), .wmask(wmask), .wbits(wbits),
        .rd_word(grp_rd)
    );

    irqd_word_bank #(.NUM_GUESTS(NUM_GUESTS), .WORDS(PRIO_WORDS)) u_prio (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_wr && dec.tgt == TGT_PRIO),
        .guest(guest_id), .idx(dec.idx), .wmask(wmask), .wbits(wbits),
        .rd_word(prio_rd)
    );

    irqd_word_bank #(.NUM_GUESTS(NUM_GUESTS), .WORDS(ROUTE_WORDS), .RO_WORDS(ROUTE_RO)) u_route (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_wr && dec.tgt == TGT_ROUTE),
        .guest(guest_id), .idx(dec.idx), .wmask(wmask), .wbits(wbits),
        .rd_word(route_rd)
    );

    irqd_word_bank #(.NUM_GUESTS(NUM_GUESTS), .WORDS(CFG_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_wr && dec.tgt == TGT_CFG),
        .guest(guest_id), .idx(dec.idx), .wmask(wmask), .wbits(wbits),
        .rd_word(cfg_rd)
    );

    irqd_enable_bank #(.NUM_GUESTS(NUM_GUESTS), .WORDS(GRP_WORDS)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_en(acc_wr && dec.tgt == TGT_EN_SET),
        .clr_en(acc_wr && dec.tgt == TGT_EN_CLR),
        .guest(guest_id), .idx(dec.idx), .wmask(wmask), .wbits(wbits),
        .rd_word(en_rd),
        .chg_valid(chg_valid), .chg_guest(chg_guest),
        .chg_word(chg_word), .chg_bits(chg_bits)
    );

    // Hold one control word per guest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GUESTS; g++)
                ctrl_q[g] <= '0;
        end else if (acc_wr && dec.tgt == TGT_CTRL) begin
            ctrl_q[guest_id] <= req_wdata;
        end
    end

    // Select the addressed word and cut out the requested lane.
    always_comb begin
        case (dec.tgt)
            TGT_CTRL:               rd_word = ctrl_q[guest_id];
            TGT_TYPE:               rd_word = TYPE_VAL;
            TGT_IDENT:              rd_word = IDENT_VALUE;
            TGT_GROUP:              rd_word = grp_rd;
            TGT_EN_SET, TGT_EN_CLR: rd_word = en_rd;
            TGT_PRIO:               rd_word = prio_rd;
            TGT_ROUTE:              rd_word = route_rd;
            TGT_CFG:                rd_word = cfg_rd;
            default:                rd_word = 32'h0;
        endcase
        rdata_d = dec.err ? 32'h0 : lane_read(req_size, req_addr[1:0], rd_word);
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rdata_d : 32'h0;
            rsp_err   <= req_valid && dec.err;
        end
    end

endmodule

// File: rtl/irqd_checker.sv
// Protocol checker for the distributor register bank, attached by bind.
// Watches only the top-level ports; assumes synchronous active-low reset.
module irqd_checker #(
    parameter int NUM_LINES  = 128,
    parameter int NUM_GUESTS = 2,
    localparam int GUEST_W = $clog2(NUM_GUESTS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [11:0]        req_addr,
    input logic [1:0]         req_size,
    input logic [31:0]        req_wdata,
    input logic [GUEST_W-1:0] guest_id,
    input logic               rsp_valid,
    input logic [31:0]        rsp_rdata,
    input logic               rsp_err,
    input logic               chg_valid,
    input logic [GUEST_W-1:0] chg_guest
);
    logic unimpl_region;
    assign unimpl_region = (req_addr[11:8] == 4'h2) || (req_addr[11:8] == 4'h3) ||
                           (req_addr[11:8] >= 4'hD);

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

    assert_const_write_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr == 12'h004 || req_addr == 12'h008)) |=> rsp_err);

    assert_type_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 12'h004 && req_size == 2'd2)
        |=> (rsp_rdata == 32'(NUM_LINES / 32 - 1)));

    assert_zero_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[11:8] == 4'h1 && req_wdata == 32'h0) |=> !chg_valid);

    assert_notify_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (rsp_valid && !rsp_err));

    assert_notify_guest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (chg_guest == $past(guest_id)));

    assert_ro_route_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[11:8] == 4'h8 && req_addr[7:5] == 3'd0 &&
         req_size == 2'd2) |=> !rsp_err);

    assert_unimpl_region_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && unimpl_region) |=> rsp_err);

endmodule

bind irq_dist_regbank irqd_checker #(.NUM_LINES(NUM_LINES), .NUM_GUESTS(NUM_GUESTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_size (req_size),
    .req_wdata(req_wdata),
    .guest_id (guest_id),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .chg_valid(chg_valid),
    .chg_guest(chg_guest)
);

// File: tb/irq_dist_regbank_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every implemented word of each array and each
// enable lane, with expected values worked out arithmetically.
module irq_dist_regbank_tb;
    localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2, SX = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [0:0]  guest_id = '0;
    logic        rsp_valid, rsp_err, chg_valid;
    logic [31:0] rsp_rdata, chg_bits;
    logic [0:0]  chg_guest;
    logic [1:0]  chg_word;

    logic        r_vld, r_err, c_vld;
    logic [31:0] r_data, c_bits;
    logic [1:0]  c_word;
    logic [0:0]  c_guest;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    irq_dist_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .guest_id(guest_id),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .chg_valid(chg_valid), .chg_guest(chg_guest), .chg_word(chg_word), .chg_bits(chg_bits)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input logic g);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
        req_wdata = d; guest_id = g;
        @(negedge clk);
        r_vld = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
        c_vld = chg_valid; c_bits = chg_bits; c_word = chg_word; c_guest = chg_guest;
        req_valid = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_en;
        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 0);
        chk("R8 reset chg_valid", {31'b0, chg_valid}, 0);
        rst_n = 1'b1;

        // R2 / R3: control, type and identification words
        acc(0, 12'h000, SW, 0, 0);
        chk("R1 read rsp_valid", {31'b0, r_vld}, 1);
        chk("R2 ctrl reset", r_data, 0);
        acc(0, 12'h004, SW, 0, 0); chk("R3 type value", r_data, 32'd3);
        acc(0, 12'h008, SW, 0, 0); chk("R3 ident value", r_data, 32'h43B);
        acc(1, 12'h004, SW, 32'hFFFF_FFFF, 0); chk("R3 type write err", {31'b0, r_err}, 1);
        acc(1, 12'h008, SW, 32'h1, 0); chk("R3 ident write err", {31'b0, r_err}, 1);
        acc(0, 12'h004, SW, 0, 0); chk("R3 type unchanged", r_data, 32'd3);
        for (int g = 0; g < 2; g++) acc(1, 12'h000, SW, 32'hC0DE_0000 + g, g[0]);
        for (int g = 0; g < 2; g++) begin
            acc(0, 12'h000, SW, 0, g[0]);
            chk("R13 ctrl per guest", r_data, 32'hC0DE_0000 + g);
        end
        acc(1, 12'h000, SH, 32'h1, 0); chk("R2 ctrl halfword err", {31'b0, r_err}, 1);
        acc(0, 12'h000, SW, 0, 0); chk("R1 err write no effect", r_data, 32'hC0DE_0000);

        // R4: group words
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < 4; i++)
                acc(1, 12'(12'h080 + 4 * i), SW, 32'h1111_1111 * (i + 1) + 32'(g), g[0]);
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < 4; i++) begin
                acc(0, 12'(12'h080 + 4 * i), SW, 0, g[0]);
                chk("R4 group readback", r_data, 32'h1111_1111 * (i + 1) + 32'(g));
            end
        acc(0, 12'h090, SW, 0, 0); chk("R4 group idx 4 err", {31'b0, r_err}, 1);
        acc(0, 12'h00C, SW, 0, 0); chk("R4 unlisted offset err", {31'b0, r_err}, 1);

        // R5 / R7 / R8: word access through both windows
        acc(1, 12'h104, SW, 32'h0000_00F0, 0);
        chk("R8 notify valid", {31'b0, c_vld}, 1);
        chk("R8 notify word", {30'b0, c_word}, 1);
        chk("R8 notify bits", c_bits, 32'hF0);
        chk("R8 notify guest", {31'b0, c_guest}, 0);
        chk("R8 response ok", {31'b0, r_err}, 0);
        acc(0, 12'h184, SW, 0, 0); chk("R5 clear window read", r_data, 32'hF0);
        acc(1, 12'h184, SW, 32'h30, 0); chk("R5 clear result", c_bits, 32'hC0);
        acc(0, 12'h104, SW, 0, 0); chk("R5 set window read", r_data, 32'hC0);
        acc(1, 12'h104, SW, 0, 0);
        chk("R7 zero set no notify", {31'b0, c_vld}, 0);
        chk("R7 zero set no err", {31'b0, r_err}, 0);
        acc(1, 12'h184, SW, 0, 0); chk("R7 zero clear no notify", {31'b0, c_vld}, 0);
        acc(0, 12'h104, SW, 0, 0); chk("R7 word unchanged", r_data, 32'hC0);

        // R6: byte lanes through the set window, guest 1 word 2
        exp_en = 32'h0;
        for (int ln = 0; ln < 4; ln++) begin
            logic [7:0] d8;
            d8 = 8'h81 ^ 8'(ln);
            exp_en = exp_en | ({24'h0, d8} << (8 * ln));
            acc(1, 12'(12'h108 + ln), SB, {24'hFFFF_FF, d8}, 1);
            chk("R6 byte set bits", c_bits, exp_en);
            chk("R8 byte set word", {30'b0, c_word}, 2);
            chk("R8 byte set guest", {31'b0, c_guest}, 1);
            acc(0, 12'(12'h108 + ln), SB, 0, 1);
            chk("R6 byte read lane", r_data, {24'h0, d8});
        end
        acc(1, 12'h18A, SH, 32'hFFFF_0081, 1);
        exp_en = exp_en & ~32'h0081_0000;
        chk("R6 half clear bits", c_bits, exp_en);
        acc(0, 12'h10A, SH, 0, 1); chk("R6 half read upper", r_data, exp_en >> 16);
        acc(0, 12'h108, SW, 0, 1); chk("R6 word after lanes", r_data, exp_en);
        acc(1, 12'h108, SX, 32'h1, 1); chk("R6 size code 3 err", {31'b0, r_err}, 1);
        acc(0, 12'h110, SW, 0, 0); chk("R5 offset 0x110 err", {31'b0, r_err}, 1);
        acc(0, 12'h190, SW, 0, 0); chk("R5 offset 0x190 err", {31'b0, r_err}, 1);
        acc(0, 12'h108, SW, 0, 0); chk("R13 enable per guest", r_data, 0);

        // R9: priority words
        for (int i = 0; i < 32; i++)
            acc(1, 12'(12'h400 + 4 * i), SW, 32'h1000_0000 + 32'h0101_0101 * i, 0);
        for (int i = 0; i < 32; i++) begin
            acc(0, 12'(12'h400 + 4 * i), SW, 0, 0);
            chk("R9 priority readback", r_data, 32'h1000_0000 + 32'h0101_0101 * i);
        end
        acc(1, 12'h400, SB, 32'hFF, 0); chk("R2 priority byte err", {31'b0, r_err}, 1);
        acc(0, 12'h400, SW, 0, 0); chk("R1 priority unchanged", r_data, 32'h1000_0000);
        acc(0, 12'h480, SW, 0, 0); chk("R9 priority idx 32 err", {31'b0, r_err}, 1);
        acc(0, 12'h404, SW, 0, 1); chk("R13 priority guest 1", r_data, 0);

        // R10: target words
        for (int i = 0; i < 32; i++)
            acc(1, 12'(12'h800 + 4 * i), SW, 32'hA500_0000 | 32'(i), 0);
        for (int i = 0; i < 32; i++) begin
            acc(0, 12'(12'h800 + 4 * i), SW, 0, 0);
            chk("R10 target readback", r_data, (i < 8) ? 32'h0 : (32'hA500_0000 | 32'(i)));
            chk("R10 target no err", {31'b0, r_err}, 0);
        end
        acc(1, 12'h822, SB, 32'h3C, 0); chk("R10 byte write ok", {31'b0, r_err}, 0);
        acc(0, 12'h822, SB, 0, 0); chk("R10 byte read", r_data, 32'h3C);
        acc(0, 12'h820, SW, 0, 0); chk("R10 word after byte", r_data, 32'hA53C_0008);
        acc(1, 12'h80E, SH, 32'hBEEF, 0); chk("R10 ro half no err", {31'b0, r_err}, 0);
        acc(0, 12'h80C, SW, 0, 0); chk("R10 ro word stays zero", r_data, 0);
        acc(0, 12'h880, SW, 0, 0); chk("R10 idx 32 err", {31'b0, r_err}, 1);

        // R11: configuration words
        for (int i = 0; i < 8; i++) acc(1, 12'(12'hC00 + 4 * i), SW, 32'h5555_0000 + 32'(i * 3), 1);
        for (int i = 0; i < 8; i++) begin
            acc(0, 12'(12'hC00 + 4 * i), SW, 0, 1);
            chk("R11 config readback", r_data, 32'h5555_0000 + 32'(i * 3));
        end
        acc(0, 12'hC20, SW, 0, 1); chk("R11 idx 8 err", {31'b0, r_err}, 1);
        acc(1, 12'hC00, SH, 32'h1, 1); chk("R2 config half err", {31'b0, r_err}, 1);

        // R12: unimplemented regions
        for (int k = 0; k < 5; k++) begin
            logic [3:0] rg;
            rg = (k == 0) ? 4'h2 : (k == 1) ? 4'h3 : 4'(4'hB + k);
            acc(1, {rg, 8'h04}, SW, 32'hFFFF_FFFF, 0);
            chk("R12 write err", {31'b0, r_err}, 1);
            acc(0, {rg, 8'h04}, SW, 0, 0);
            chk("R12 read err", {31'b0, r_err}, 1);
            chk("R12 read zero", r_data, 0);
        end
        acc(0, 12'h104, SW, 0, 0); chk("R12 enables untouched", r_data, 32'hC0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule